// File: doc/BRIEF.md
# Byte-Lane RAM with Address Hold

A synchronous single-clock memory. The address is registered, each byte lane has its own write enable, and the read port has one clock of latency. Each port has an active-high hold input. While the hold input is high, the port's address register keeps its current value, so reads and writes stay on the location that was captured last. The register is built as a two-way choice between its own output and the new address.

When a lane is written, the read data for that lane in the same cycle is set by a parameter. It is either the byte being written or the byte that was stored there before. A lane that is not enabled always returns the stored byte.

A parameter selects one of two layouts. In the wide layout, port A owns the whole array and port B is dormant. In the packed layout, the array is split into two independent single-port memories of the same width. Port A owns the lower half and port B owns the upper half. The top address bit of each port is replaced by the port's own half select.

Top module: `bytelane_ram`

## Requirements
- R1: With hold low, the address presented at a rising edge is registered at that edge. Read data for that location appears on `*_rdata` after the same edge, one cycle of latency.
- R2: With hold high, the port ignores its address input and reads or writes the location held in its address register. That register keeps its value for every cycle the hold stays high.
- R3: A write changes only the lanes whose enable bit is 1. Bit 0 of `*_be` controls `*_wdata[LANE_W-1:0]` and bit 1 controls the next lane up. Other lanes keep their stored contents.
- R4: In a write cycle, a lane whose enable bit is 0 returns the contents stored at that location before the write.
- R5: In a write cycle, a lane whose enable bit is 1 returns the written byte when NEW_DATA=1, and the previously stored byte when NEW_DATA=0.
- R6: With PACKED=1, port A always uses the lower half of the array (top address bit 0) and port B the upper half (top bit 1), whatever is driven on the top address bit. Neither port ever sees the other's data.
- R7: The two ports have separate hold inputs. Holding one port does not affect the other port's address.
- R8: With PACKED=0, all port B inputs are ignored and `b_rdata` stays 0.
- R9: During reset and after it, both `*_rdata` outputs read 0 until the first access, and both address registers hold 0. Memory contents are not reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset of address and read registers |
| a_stall | input | 1 | Port A address hold |
| a_addr | input | AW | Port A address |
| a_we | input | 1 | Port A write |
| a_be | input | LANES | Port A lane enables |
| a_wdata | input | LANE_W*LANES | Port A write data |
| a_rdata | output | LANE_W*LANES | Port A read data |
| b_stall | input | 1 | Port B address hold |
| b_addr | input | AW | Port B address |
| b_we | input | 1 | Port B write |
| b_be | input | LANES | Port B lane enables |
| b_wdata | input | LANE_W*LANES | Port B write data |
| b_rdata | output | LANE_W*LANES | Port B read data |

## Verification
The bench runs a wide instance in new-data mode next to a packed instance in old-data mode. It sweeps every address against every lane-enable pattern. A lane mux wired the wrong way would show the written byte where the stored byte is expected, or the reverse, and a merge fault would corrupt the lane that was not enabled. Hold patterns that differ per port and drive a changing address catch a register that reloads while held, and a hold that leaks from one port to the other. The packed instance drives the wrong top address bit, so a half select taken from the pin would let the two ports overwrite each other. The first access after reset is made with hold high, so it must land on word 0.

// File: rtl/bytelane_ram.sv
module bytelane_ram #(
  parameter int LANE_W   = 9,
  parameter int LANES    = 2,
  parameter int DEPTH    = 512,
  parameter bit PACKED   = 1'b0,
  parameter bit NEW_DATA = 1'b1,
  localparam int DW = LANE_W * LANES,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             a_stall,
  input  logic [AW-1:0]    a_addr,
  input  logic             a_we,
  input  logic [LANES-1:0] a_be,
  input  logic [DW-1:0]    a_wdata,
  output logic [DW-1:0]    a_rdata,
  input  logic             b_stall,
  input  logic [AW-1:0]    b_addr,
  input  logic             b_we,
  input  logic [LANES-1:0] b_be,
  input  logic [DW-1:0]    b_wdata,
  output logic [DW-1:0]    b_rdata
);
  localparam int NP = PACKED ? 2 : 1;

  logic [DW-1:0]    mem [DEPTH];
  logic [AW-1:0]    in_addr [2];
  logic [AW-1:0]    addr_q  [2];
  logic [AW-1:0]    ea      [2];
  logic             in_stall[2];
  logic             in_we   [2];
  logic [LANES-1:0] in_be   [2];
  logic [DW-1:0]    in_wd   [2];
  logic [DW-1:0]    rd_q    [2];

  assign in_addr[0] = a_addr;  assign in_addr[1] = b_addr;
  assign in_stall[0] = a_stall; assign in_stall[1] = b_stall;
  assign in_we[0] = a_we;      assign in_we[1] = b_we;
  assign in_be[0] = a_be;      assign in_be[1] = b_be;
  assign in_wd[0] = a_wdata;   assign in_wd[1] = b_wdata;
  assign a_rdata = rd_q[0];
  assign b_rdata = rd_q[1];

  for (genvar p = 0; p < 2; p++) begin : g_port
    logic [AW-1:0] pick;
    assign pick = in_stall[p] ? addr_q[p] : in_addr[p];
    if (PACKED) begin : g_half
      assign ea[p] = {(p == 1), pick[AW-2:0]};
    end else begin : g_full
      assign ea[p] = pick;
    end
  end

  always_ff @(posedge clk) begin
    for (int p = 0; p < 2; p++) begin
      if (!rst_n) begin
        addr_q[p] <= '0;
        rd_q[p]   <= '0;
      end else if (p < NP) begin
        addr_q[p] <= ea[p];
        for (int l = 0; l < LANES; l++)
          rd_q[p][l*LANE_W +: LANE_W] <= (NEW_DATA && in_we[p] && in_be[p][l])
            ? in_wd[p][l*LANE_W +: LANE_W] : mem[ea[p]][l*LANE_W +: LANE_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int p = 0; p < NP; p++)
      if (rst_n && in_we[p])
        for (int l = 0; l < LANES; l++)
          if (in_be[p][l]) mem[ea[p]][l*LANE_W +: LANE_W] <= in_wd[p][l*LANE_W +: LANE_W];
  end

  a_r2_hold_keeps_addr: assert property (@(posedge clk) disable iff (!rst_n)
    a_stall |=> addr_q[0] == $past(addr_q[0]));
  a_r7_b_hold_keeps_addr: assert property (@(posedge clk) disable iff (!rst_n)
    b_stall |=> addr_q[1] == $past(addr_q[1]));
  a_r1_addr_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (!PACKED && !a_stall) |=> addr_q[0] == $past(a_addr));
  a_r5_new_bytes_shown: assert property (@(posedge clk) disable iff (!rst_n)
    (NEW_DATA && a_we && (&a_be)) |=> a_rdata == $past(a_wdata));
  a_r6_halves_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
    PACKED |=> (!addr_q[0][AW-1] && addr_q[1][AW-1]));
  a_r8_b_dormant: assert property (@(posedge clk) disable iff (!rst_n)
    !PACKED |-> b_rdata == '0);
endmodule

// File: tb/tb_bytelane_ram.sv
module tb_bytelane_ram;
  localparam int LW = 9, DW = 18, D = 16, AW = 4;

  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic          wa_stall = 0, wa_we = 0, wb_stall = 0, wb_we = 0;
  logic [AW-1:0] wa_addr = 0, wb_addr = 0;
  logic [1:0]    wa_be = 0, wb_be = 0;
  logic [DW-1:0] wa_wd = 0, wb_wd = 0, wa_rd, wb_rd;
  logic          pa_stall = 0, pa_we = 0, pb_stall = 0, pb_we = 0;
  logic [AW-1:0] pa_addr = 0, pb_addr = 0;
  logic [1:0]    pa_be = 0, pb_be = 0;
  logic [DW-1:0] pa_wd = 0, pb_wd = 0, pa_rd, pb_rd;

  bytelane_ram #(.LANE_W(LW), .LANES(2), .DEPTH(D), .PACKED(1'b0), .NEW_DATA(1'b1)) dut (
    .clk, .rst_n, .a_stall(wa_stall), .a_addr(wa_addr), .a_we(wa_we), .a_be(wa_be),
    .a_wdata(wa_wd), .a_rdata(wa_rd), .b_stall(wb_stall), .b_addr(wb_addr), .b_we(wb_we),
    .b_be(wb_be), .b_wdata(wb_wd), .b_rdata(wb_rd));

  bytelane_ram #(.LANE_W(LW), .LANES(2), .DEPTH(D), .PACKED(1'b1), .NEW_DATA(1'b0)) dut_pk (
    .clk, .rst_n, .a_stall(pa_stall), .a_addr(pa_addr), .a_we(pa_we), .a_be(pa_be),
    .a_wdata(pa_wd), .a_rdata(pa_rd), .b_stall(pb_stall), .b_addr(pb_addr), .b_we(pb_we),
    .b_be(pb_be), .b_wdata(pb_wd), .b_rdata(pb_rd));

  int n_run = 0, n_fail = 0;
  logic [DW-1:0] wm [D];
  logic [DW-1:0] pm [D];
  logic [AW-1:0] waq = 0, paq = 0, pbq = 0;
  bit pk_chk = 0;
  string tag = "R1";

  task automatic check(string t, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h at %0t", t, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] step(ref logic [DW-1:0] m [D], input logic [AW-1:0] ea,
      input logic we, input logic [1:0] be, input logic [DW-1:0] wd, input bit newd);
    logic [DW-1:0] old = m[ea], r = m[ea];
    for (int l = 0; l < 2; l++)
      if (we && be[l]) begin
        if (newd) r[l*LW +: LW] = wd[l*LW +: LW];
        m[ea][l*LW +: LW] = wd[l*LW +: LW];
      end
    if (!newd) r = old;
    return r;
  endfunction

  task automatic tick();
    logic [AW-1:0] ew, e0, e1;
    logic [DW-1:0] xw, x0, x1;
    ew = wa_stall ? waq : wa_addr;
    xw = step(wm, ew, wa_we, wa_be, wa_wd, 1'b1);
    waq = ew;
    e0 = {1'b0, (pa_stall ? paq[2:0] : pa_addr[2:0])};
    e1 = {1'b1, (pb_stall ? pbq[2:0] : pb_addr[2:0])};
    x0 = step(pm, e0, pa_we, pa_be, pa_wd, 1'b0);
    x1 = step(pm, e1, pb_we, pb_be, pb_wd, 1'b0);
    paq = e0; pbq = e1;
    @(posedge clk); @(negedge clk);
    check({tag, " wide A"}, wa_rd, xw);
    check("R8 wide B dormant", wb_rd, '0);
    if (pk_chk) begin
      check({tag, "/R6 packed A"}, pa_rd, x0);
      check({tag, "/R6 packed B"}, pb_rd, x1);
    end
  endtask

  function automatic logic [DW-1:0] pat(int i);
    return DW'(i * 10007 + 321);
  endfunction

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset A", wa_rd, '0); check("R9 reset pk A", pa_rd, '0); check("R9 reset pk B", pb_rd, '0);
    rst_n = 1;
    check("R9 after reset A", wa_rd, '0); check("R9 after reset pk B", pb_rd, '0);
    // R9: first write with hold high must go to word 0
    tag = "R9";
    wa_stall = 1; wa_addr = 9; wa_we = 1; wa_be = 2'b11; wa_wd = pat(999);
    tick();
    wa_stall = 0;
    tag = "R1";
    for (int i = 0; i < D; i++) begin
      wa_addr = AW'(i); wa_we = 1; wa_be = 2'b11; wa_wd = pat(i);
      wb_addr = AW'(15 - i); wb_we = 1; wb_be = 2'b11; wb_wd = pat(i + 50);
      pa_addr = AW'(i | 8); pa_we = 1; pa_be = 2'b11; pa_wd = pat(i + 100);
      pb_addr = AW'(i & 7); pb_we = 1; pb_be = 2'b11; pb_wd = pat(i + 200);
      tick();
    end
    pk_chk = 1;
    wa_we = 0; pa_we = 0; pb_we = 0;
    for (int i = 0; i < D; i++) begin
      wa_addr = AW'(i); pa_addr = AW'(i); pb_addr = AW'(i); tick();
    end
    for (int a = 0; a < D; a++)
      for (int b = 0; b < 4; b++) begin
        tag = (b == 0) ? "R4" : (b == 3) ? "R5" : "R3";
        wa_addr = AW'(a); wa_we = 1; wa_be = 2'(b); wa_wd = pat(a * 4 + b + 300);
        wb_we = 1; wb_be = 2'(b); wb_wd = pat(a + 7);
        pa_addr = AW'(a); pa_we = 1; pa_be = 2'(b); pa_wd = pat(a * 4 + b + 500);
        pb_addr = AW'(15 - a); pb_we = 1; pb_be = 2'(3 - b); pb_wd = pat(a * 4 + b + 700);
        tick();
        wa_we = 0; pa_we = 0; pb_we = 0; tag = "R3";
        tick();
      end
    for (int i = 0; i < 60; i++) begin
      tag = "R2/R7";
      wa_stall = (i % 3 == 0); wa_addr = AW'(i * 5); wa_we = (i % 4 == 1); wa_be = 2'(i);
      wa_wd = pat(i + 900);
      pa_stall = (i % 2 == 0); pa_addr = AW'(i * 3); pa_we = (i % 3 == 2); pa_be = 2'(i + 1);
      pa_wd = pat(i + 1000);
      pb_stall = (i % 5 == 1); pb_addr = AW'(i * 7); pb_we = (i % 4 == 3); pb_be = 2'(i + 2);
      pb_wd = pat(i + 1100);
      tick();
    end
    wa_stall = 0; pa_stall = 0; pb_stall = 0; wa_we = 0; pa_we = 0; pb_we = 0; tag = "R3/R6";
    for (int i = 0; i < D; i++) begin
      wa_addr = AW'(i); pa_addr = AW'(i); pb_addr = AW'(i); tick();
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule